// File: doc/BRIEF.md
# Sequential AES-128 Round Key Expander

This block turns a 128-bit cipher key into the eleven 128-bit round keys that AES-128 needs. It works one 32-bit schedule word per clock. The key is captured while reset is high. After reset is released, forty clock edges produce words 4 through 43. All eleven round keys are then held in registers side by side, so a fully pipelined round datapath can read every round key in the same cycle.

A direction input picks the order in which the stored keys reach the stage outputs. For encryption, stage `s` receives round key `s`. For decryption, stage `s` receives round key `10-s`. The `ready` flag tells the surrounding datapath when it may start to accept data. Data offered before `ready` is high must not be admitted. The block carries no data stream of its own, so it has no back-pressure: `ready` is a plain level, and there is no handshake with a partner. Loading a new key means asserting reset again while the new key is on `key_in`.

Top module: `rkx_expander`

## Requirements
- R1: While `rst` is high, `ready` is 0. Schedule words 0..3 take the value of `key_in` sampled at the last clock edge with `rst` high. Word 0 is `key_in[127:96]` and word 3 is `key_in[31:0]`. Round key 0 therefore equals that sampled key.
- R2: `ready` is 0 after the 39th rising edge following the release of reset, and it is 1 after the 40th.
- R3: For each index i from 4 to 43 that is not a multiple of 4, word i = word(i-4) XOR word(i-1).
- R4: For each index i that is a multiple of 4, word i = word(i-4) XOR SubWord(RotWord(word(i-1))) XOR {rc, 24'h0}. RotWord moves the top byte to the bottom. SubWord applies the AES S-box to each byte. rc is 01,02,04,08,10,20,40,80,1B,36 for i/4 = 1..10. For example, key 2B7E151628AED2A6ABF7158809CF4F3C gives round key 1 = A0FAFE1788542CB123A339392A6C7605, and the all-zero key gives round key 10 = B4EF5BCB3E92E21123E951CF6F8F188E.
- R5: Round key k consists of words 4k..4k+3, with word 4k in the most significant 32 bits. Stage s is driven on `stage_keys[128*s +: 128]`.
- R6: With `decrypt` = 0, stage s carries round key s. With `decrypt` = 1, stage s carries round key 10-s. A change of `decrypt` shows at the outputs without a clock edge.
- R7: Once `ready` is 1, the stored round keys do not change until the next reset, whatever `key_in` does.
- R8: For key 2B7E151628AED2A6ABF7158809CF4F3C, round key 10 equals D014F9A8C9EE2589E13F0CC8B6630CA6.
- R9: Once `ready` has risen, it stays 1 until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; the key is captured while it is high |
| key_in | input | 128 | Cipher key |
| decrypt | input | 1 | 0 = forward key order, 1 = reversed key order |
| ready | output | 1 | High once the whole schedule is stored |
| stage_keys | output | 1408 | Eleven 128-bit round keys; stage s sits at bits [128*s +: 128] |

## Verification
`ready` is due on the 40th rising edge after reset falls. The bench releases reset on a falling edge and counts exactly 39 rising edges before it samples the low value. It then samples the high value one edge later, always at the falling edge. Round key contents are compared only after `ready` is seen high, and all samples are taken at falling edges. Direction changes are combinational, so their results are sampled a short delay after `decrypt` is driven, with no clock edge in between. The test that `key_in` is ignored waits ten more edges after the key changes and then compares every stage again against the old schedule.

// File: rtl/rkx_pkg.sv
package rkx_pkg;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse in GF(2^8); zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon_of(input int k);
    logic [7:0] r;
    r = 8'h01;
    for (int j = 1; j < k; j++) r = xtime(r);
    return r;
  endfunction

endpackage

// File: rtl/rkx_sbox.sv
module rkx_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import rkx_pkg::*;

  always_comb begin
    dout = affine(gf_inv(din));
  end
endmodule

// File: rtl/rkx_word_gen.sv
module rkx_word_gen #(
  parameter int WORD_W = 32,
  parameter int NK     = 4,
  parameter int IDX_W  = 6
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] back_word,
  output logic [WORD_W-1:0] next_word
);
  import rkx_pkg::*;

  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] rotated;
  logic [WORD_W-1:0] subbed;
  logic [WORD_W-1:0] temp;

  assign rotated = {prev_word[WORD_W-9:0], prev_word[WORD_W-1:WORD_W-8]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    rkx_sbox u_sbox (
      .din  (rotated[8*b +: 8]),
      .dout (subbed[8*b +: 8])
    );
  end

  always_comb begin
    int unsigned ii;
    ii = int'(idx);
    if ((ii % NK) == 0)
      temp = subbed ^ {rcon_of(int'(ii / NK)), {(WORD_W-8){1'b0}}};
    else
      temp = prev_word;
    next_word = back_word ^ temp;
  end
endmodule

// File: rtl/rkx_store.sv
module rkx_store #(
  parameter int WORD_W = 32,
  parameter int NK     = 4,
  parameter int ROUNDS = 10,
  parameter int IDX_W  = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NK*WORD_W-1:0]               key_in,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [WORD_W-1:0]                  wr_data,
  output logic [(ROUNDS+1)*NK*WORD_W-1:0]    sched_flat
);
  localparam int KEY_W  = NK * WORD_W;
  localparam int NWORDS = NK * (ROUNDS + 1);

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    localparam int OFS = KEY_W * (j / NK) + WORD_W * (NK - 1 - (j % NK));
    logic [WORD_W-1:0] word_q;

    if (j < NK) begin : g_key
      always_ff @(posedge clk) begin
        if (rst) word_q <= key_in[WORD_W*(NK-1-j) +: WORD_W];
      end
    end else begin : g_derived
      always_ff @(posedge clk) begin
        if (rst)
          word_q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(j)))
          word_q <= wr_data;
      end
    end

    assign sched_flat[OFS +: WORD_W] = word_q;
  end
endmodule

// File: rtl/rkx_order.sv
module rkx_order #(
  parameter int KEY_W  = 128,
  parameter int ROUNDS = 10
) (
  input  logic                          decrypt,
  input  logic [(ROUNDS+1)*KEY_W-1:0]   fwd_keys,
  output logic [(ROUNDS+1)*KEY_W-1:0]   stage_keys
);
  for (genvar s = 0; s <= ROUNDS; s++) begin : g_stage
    assign stage_keys[KEY_W*s +: KEY_W] =
      decrypt ? fwd_keys[KEY_W*(ROUNDS-s) +: KEY_W] : fwd_keys[KEY_W*s +: KEY_W];
  end
endmodule

// File: rtl/rkx_expander.sv
module rkx_expander #(
  parameter int WORD_W = 32,
  parameter int NK     = 4,
  parameter int ROUNDS = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NK*WORD_W-1:0]                 key_in,
  input  logic                                 decrypt,
  output logic                                 ready,
  output logic [(ROUNDS+1)*NK*WORD_W-1:0]      stage_keys
);
  localparam int KEY_W  = NK * WORD_W;
  localparam int NWORDS = NK * (ROUNDS + 1);
  localparam int IDX_W  = $clog2(NWORDS + 1);

  logic [IDX_W-1:0]                 idx_q;
  logic [WORD_W-1:0]                win_q [NK];
  logic [WORD_W-1:0]                new_word;
  logic                             wr_en;
  logic [(ROUNDS+1)*KEY_W-1:0]      sched_flat;

  assign wr_en = !rst && (idx_q < IDX_W'(NWORDS));
  assign ready = !rst && (idx_q == IDX_W'(NWORDS));

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= IDX_W'(NK);
    else if (wr_en)
      idx_q <= idx_q + 1'b1;
  end

  // sliding window holding words i-NK .. i-1
  for (genvar m = 0; m < NK; m++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)
        win_q[m] <= key_in[WORD_W*(NK-1-m) +: WORD_W];
      else if (wr_en)
        win_q[m] <= (m == NK-1) ? new_word : win_q[(m+1) % NK];
    end
  end

  rkx_word_gen #(.WORD_W(WORD_W), .NK(NK), .IDX_W(IDX_W)) u_gen (
    .idx       (idx_q),
    .prev_word (win_q[NK-1]),
    .back_word (win_q[0]),
    .next_word (new_word)
  );

  rkx_store #(.WORD_W(WORD_W), .NK(NK), .ROUNDS(ROUNDS), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .key_in     (key_in),
    .wr_en      (wr_en),
    .wr_idx     (idx_q),
    .wr_data    (new_word),
    .sched_flat (sched_flat)
  );

  rkx_order #(.KEY_W(KEY_W), .ROUNDS(ROUNDS)) u_order (
    .decrypt    (decrypt),
    .fwd_keys   (sched_flat),
    .stage_keys (stage_keys)
  );
endmodule

// File: rtl/rkx_expander_chk.sv
module rkx_expander_chk #(
  parameter int KEY_W  = 128,
  parameter int ROUNDS = 10
) (
  input logic                          clk,
  input logic                          rst,
  input logic [KEY_W-1:0]              key_in,
  input logic                          decrypt,
  input logic                          ready,
  input logic [(ROUNDS+1)*KEY_W-1:0]   stage_keys,
  input logic [(ROUNDS+1)*KEY_W-1:0]   sched_flat
);
  localparam int RUN = (ROUNDS + 1) * (KEY_W / 32) - (KEY_W / 32);

  logic [15:0] since_rel;
  always_ff @(posedge clk) begin
    if (rst)
      since_rel <= '0;
    else if (since_rel != 16'hffff)
      since_rel <= since_rel + 1'b1;
  end

  assert_ready_timing_R2: assert property (@(posedge clk) disable iff (rst)
    ready == (since_rel >= 16'(RUN)));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_keys_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(sched_flat));

  assert_key_capture_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> sched_flat[KEY_W-1:0] == $past(key_in));

  assert_fwd_stage_R6: assert property (@(posedge clk) disable iff (rst)
    !decrypt |-> stage_keys[KEY_W-1:0] == sched_flat[KEY_W-1:0]);

  assert_rev_stage_R6: assert property (@(posedge clk) disable iff (rst)
    decrypt |-> stage_keys[KEY_W-1:0] == sched_flat[KEY_W*ROUNDS +: KEY_W]);
endmodule

bind rkx_expander rkx_expander_chk #(.KEY_W(KEY_W), .ROUNDS(ROUNDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .key_in     (key_in),
  .decrypt    (decrypt),
  .ready      (ready),
  .stage_keys (stage_keys),
  .sched_flat (sched_flat)
);

// File: tb/rkx_expander_test.sv
`timescale 1ns/1ps
module rkx_expander_test;
  localparam int NR = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [127:0]      key_in = '0;
  logic              decrypt = 1'b0;
  logic              ready;
  logic [1407:0]     stage_keys;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [7:0]   sbox_t [256];
  logic [127:0] exp_key_q [$];
  int           exp_stage_q [$];

  always #2 clk = ~clk;

  rkx_expander uut (
    .clk        (clk),
    .rst        (rst),
    .key_in     (key_in),
    .decrypt    (decrypt),
    .ready      (ready),
    .stage_keys (stage_keys)
  );

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box table built by walking generator 3 and its inverse together
  task automatic build_sbox();
    logic [7:0] p = 8'h01;
    logic [7:0] q = 8'h01;
    sbox_t[0] = 8'h63;
    for (int n = 0; n < 255; n++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      sbox_t[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] model_rk(input logic [127:0] key, input int k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox_t[t[31:24]], sbox_t[t[23:16]], sbox_t[t[15:8]], sbox_t[t[7:0]]};
        t = t ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      w[i] = w[i-4] ^ t;
    end
    return {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_expected(input logic [127:0] key, input logic dec);
    for (int s = 0; s <= NR; s++) begin
      exp_stage_q.push_back(s);
      exp_key_q.push_back(model_rk(key, dec ? NR - s : s));
    end
  endtask

  // monitor side: pops and compares against the live outputs
  task automatic drain(input string req);
    while (exp_key_q.size() > 0) begin
      int s;
      logic [127:0] e;
      s = exp_stage_q.pop_front();
      e = exp_key_q.pop_front();
      chk($sformatf("%s stage%0d", req, s), stage_keys[128*s +: 128], e);
    end
  endtask

  task automatic reset_and_wait(input logic [127:0] key);
    @(negedge clk);
    rst = 1'b1;
    key_in = key;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", {127'd0, ready}, 128'd0);
    rst = 1'b0;
    repeat (39) @(posedge clk);
    @(negedge clk);
    chk("R2 ready after 39 edges", {127'd0, ready}, 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready after 40 edges", {127'd0, ready}, 128'd1);
  endtask

  localparam logic [127:0] KEY_A = 128'h2B7E151628AED2A6ABF7158809CF4F3C;
  localparam logic [127:0] KEY_C = 128'h000102030405060708090A0B0C0D0E0F;
  localparam logic [127:0] KEY_D = 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF;

  initial begin
    build_sbox();
    key_in = KEY_A;

    reset_and_wait(KEY_A);
    chk("R1 round key 0", stage_keys[127:0], KEY_A);
    chk("R4 round key 1", stage_keys[255:128], 128'hA0FAFE1788542CB123A339392A6C7605);
    chk("R8 final round key", stage_keys[1407:1280], 128'hD014F9A8C9EE2589E13F0CC8B6630CA6);
    push_expected(KEY_A, 1'b0);
    drain("R5 forward");

    decrypt = 1'b1;
    #1;
    push_expected(KEY_A, 1'b1);
    drain("R6 reversed");
    decrypt = 1'b0;
    #1;
    push_expected(KEY_A, 1'b0);
    drain("R6 back to forward");

    @(negedge clk);
    key_in = KEY_D;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 ready held", {127'd0, ready}, 128'd1);
    push_expected(KEY_A, 1'b0);
    drain("R7 key change ignored");

    reset_and_wait(128'd0);
    chk("R4 zero key final", stage_keys[1407:1280], 128'hB4EF5BCB3E92E21123E951CF6F8F188E);
    push_expected(128'd0, 1'b0);
    drain("R3 zero key");

    reset_and_wait(KEY_C);
    push_expected(KEY_C, 1'b0);
    drain("R3 counting key");
    decrypt = 1'b1;
    #1;
    push_expected(KEY_C, 1'b1);
    drain("R6 counting key reversed");
    decrypt = 1'b0;

    reset_and_wait(KEY_D);
    push_expected(KEY_D, 1'b0);
    drain("R4 ones key");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule